// File: doc/BRIEF.md
# DMA Command Stream Parser

The parser takes DMA instructions as a stream of 64-bit words over a valid/ready handshake. A command is one header word, then the words of its first area, then the words of its last area. The header gives the transfer kind and two 4-bit pointer counts. From these the parser works out which areas carry local memory pointers and which carry bus components. It also works out how many words each area occupies. It then walks both areas and produces one decoded descriptor per pointer on a registered valid/ready output.

A local pointer uses one word and gives a byte address and a byte size. A bus component area is packed in groups: a length word holding four 16-bit lengths comes before each group of up to four 64-bit bus addresses. While it walks the areas, the parser checks the command's legality rules. These are zero reserved bits, a word budget for the two areas together, non-zero local sizes, and equal byte totals in the two areas. On the cycle the final word of a command is accepted, it pulses a completion strobe together with an error code. The next word is then taken as a new header. The parser moves no data.

Top module: `dma_cmd_parser`

## Requirements
- R1: Header fields are reserved in bits 63:60, transfer kind in bits 59:58, first-area pointer count in bits 57:54 and last-area pointer count in bits 53:50. When both counts are zero, the command is the header word alone: `cmd_done` pulses as that header is accepted, and no descriptor is produced.
- R2: A local-pointer area takes one word per pointer. A bus-component area of N pointers takes N + floor((N+3)/4) words: a length word comes before each group of up to four addresses, and that group's lengths sit in bits 63:48, 47:32, 31:16 and 15:0 for its first to fourth address.
- R3: Kind 0 (local to bus), kind 1 (bus to local) and kind 2 (local to local) put local pointers in the first area. Kind 3 (bus to bus) puts bus components there. The last area holds local pointers only for kind 2, and bus components otherwise.
- R4: A local pointer word carries its size in bits 52:40, reserved bits 39:36 and the address in bits 35:0. Its descriptor has `out_comp`=0, `out_len` equal to the size, and `out_addr` equal to the zero-extended address. A bus component descriptor has `out_comp`=1 and the full 64-bit word as address.
- R5: Descriptors come out in stream order. `out_area` is 0 for the first area and 1 for the last area, and `out_last` is set only on the final descriptor of a command.
- R6: `cmd_done` pulses for exactly one cycle: the cycle in which the final word of a command is accepted. The next accepted word is decoded as a header.
- R7: `cmd_err` bit 0 is set at completion if header bits 63:60 or any local pointer's bits 39:36 were non-zero.
- R8: `cmd_err` bit 1 is set at completion if the word counts of the two areas together exceed 31.
- R9: `cmd_err` bit 2 is set at completion if any local pointer had a size of zero.
- R10: `cmd_err` bit 3 is set at completion if the summed byte sizes of the first area differ from those of the last area.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the descriptor outputs hold their values.
- R12: After reset, `out_valid` and `cmd_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can take the input word |
| in_data | input | 64 | Command stream word |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_area | output | 1 | 0 = first area, 1 = last area |
| out_comp | output | 1 | 1 = bus component, 0 = local pointer |
| out_last | output | 1 | Final descriptor of the command |
| out_len | output | 16 | Byte length or size |
| out_addr | output | 64 | Bus address or zero-extended local address |
| cmd_done | output | 1 | Final word of a command accepted this cycle |
| cmd_err | output | 4 | Error flags, valid with cmd_done |

## Verification
Two things can happen in the same cycle. The completion report for a command is produced from the word being accepted, and the descriptor of the previous word leaves the output register in that same cycle. The error code must therefore fold in the contribution of the accepting word itself: its reserved bits, its zero size, and its share of the byte totals. At the same time the previous descriptor must transfer exactly once. The bench provokes this by streaming commands back to back with the consumer always ready, so that every final word meets a draining descriptor. It checks the completion code on that edge, and the tagged final descriptor on the following cycle. A mismatch test whose last word alone breaks the byte balance, and a stalled-consumer test, judge the case in which the final word is held until the output frees.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  localparam int WORD_W   = 64;
  localparam int CNT_W    = 4;
  localparam int LEN_W    = 16;
  localparam int SIZE_W   = 13;
  localparam int LADDR_W  = 36;
  localparam int KIND_W   = 2;
  localparam int ERR_W    = 4;
  localparam int GROUP    = WORD_W / LEN_W;
  localparam int SLOT_W   = $clog2(GROUP + 1);
  localparam int TOT_W    = CNT_W + 2;
  localparam int SUM_W    = LEN_W + CNT_W;

  // header field positions
  localparam int HDR_RSV_HI  = 63;
  localparam int HDR_LSB     = 50;
  localparam int HDR_W       = HDR_RSV_HI - HDR_LSB + 1;

  // local pointer field positions
  localparam int LOC_SIZE_LO = 40;
  localparam int LOC_RSV_LO  = 36;
  localparam int LOC_RSV_W   = LOC_SIZE_LO - LOC_RSV_LO;

  // error code bit positions
  localparam int ERR_RSV    = 0;
  localparam int ERR_BUDGET = 1;
  localparam int ERR_ZERO   = 2;
  localparam int ERR_SUM    = 3;

  typedef enum logic [KIND_W-1:0] {
    XFER_L2B = 2'd0,
    XFER_B2L = 2'd1,
    XFER_L2L = 2'd2,
    XFER_B2B = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic              area;
    logic              comp;
    logic              last;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] addr;
  } desc_t;

  function automatic logic [TOT_W-1:0] area_words(input logic [CNT_W-1:0] n,
                                                  input logic comp);
    logic [TOT_W-1:0] nn;
    nn = TOT_W'(n);
    return comp ? nn + ((nn + TOT_W'(3)) >> 2) : nn;
  endfunction

endpackage

// File: rtl/dma_hdr_decode.sv
module dma_hdr_decode
  import dma_cmd_pkg::*;
#(
  parameter int WORD_BUDGET = 31
) (
  input  logic [HDR_W-1:0]  hdr,
  output logic [CNT_W-1:0]  n_first,
  output logic [CNT_W-1:0]  n_last,
  output logic              first_comp,
  output logic              last_comp,
  output logic              rsv_bad,
  output logic              budget_bad
);

  localparam int RSV_W  = HDR_W - KIND_W - 2 * CNT_W;
  localparam int KIND_LO = 2 * CNT_W;

  xfer_kind_e           kind;
  logic [TOT_W-1:0]     w_first;
  logic [TOT_W-1:0]     w_last;
  logic [TOT_W:0]       w_sum;

  always_comb begin
    kind       = xfer_kind_e'(hdr[KIND_LO +: KIND_W]);
    n_first    = hdr[CNT_W +: CNT_W];
    n_last     = hdr[0 +: CNT_W];
    rsv_bad    = |hdr[HDR_W-1 -: RSV_W];
    first_comp = (kind == XFER_B2B);
    last_comp  = (kind != XFER_L2L);
    w_first    = area_words(n_first, first_comp);
    w_last     = area_words(n_last, last_comp);
    w_sum      = {1'b0, w_first} + {1'b0, w_last};
    budget_bad = (w_sum > (TOT_W + 1)'(WORD_BUDGET));
  end

endmodule

// File: rtl/dma_len_unpack.sv
module dma_len_unpack
  import dma_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [SLOT_W-1:0] sel,
  output logic [LEN_W-1:0]  len
);

  localparam int IDX_W = $clog2(GROUP);

  logic [LEN_W-1:0] lens_q [GROUP];
  logic [LEN_W-1:0] lens_d [GROUP];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < GROUP; g++) begin : g_slice
    assign lens_d[g] = word[WORD_W-1-g*LEN_W -: LEN_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lens_q[g] <= '0;
      end else if (load) begin
        lens_q[g] <= lens_d[g];
      end
    end
  end

  always_comb begin
    idx = IDX_W'(sel - SLOT_W'(1));
    len = lens_q[idx];
  end

endmodule

// File: rtl/dma_size_tally.sv
module dma_size_tally
  import dma_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_first,
  input  logic             add_last,
  input  logic [LEN_W-1:0] val,
  output logic             mismatch
);

  logic [SUM_W-1:0] first_q, first_d;
  logic [SUM_W-1:0] last_q,  last_d;
  logic [SUM_W-1:0] first_tot, last_tot;

  always_comb begin
    first_tot = first_q + (add_first ? SUM_W'(val) : '0);
    last_tot  = last_q  + (add_last  ? SUM_W'(val) : '0);
    mismatch  = (first_tot != last_tot);
    first_d   = clr ? '0 : first_tot;
    last_d    = clr ? '0 : last_tot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (clr || add_first || add_last) begin
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

endmodule

// File: rtl/dma_cmd_parser.sv
module dma_cmd_parser
  import dma_cmd_pkg::*;
#(
  parameter int WORD_BUDGET = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_area,
  output logic              out_comp,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len,
  output logic [WORD_W-1:0] out_addr,
  output logic              cmd_done,
  output logic [ERR_W-1:0]  cmd_err
);

  typedef enum logic [1:0] {ST_HDR, ST_FIRST, ST_LAST} pstate_e;

  pstate_e           state_q, state_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              fcomp_q, fcomp_d;
  logic              lcomp_q, lcomp_d;
  logic [CNT_W-1:0]  nlast_q, nlast_d;
  logic [ERR_W-1:0]  err_q, err_d;
  desc_t             desc_q, desc_d;
  logic              vld_q, vld_d;

  logic [CNT_W-1:0]  dec_nf, dec_nl;
  logic              dec_fcomp, dec_lcomp, dec_rsv, dec_budget;

  logic              accept;
  logic              in_area, cur_comp, is_len_word, is_ptr;
  logic              area_end, cmd_end, hdr_only;
  logic [SIZE_W-1:0] loc_size;
  logic [LOC_RSV_W-1:0] loc_rsv;
  logic [LEN_W-1:0]  grp_len, ptr_len;
  logic [WORD_W-1:0] ptr_addr;
  logic [ERR_W-1:0]  cur_flags;
  logic              sum_bad;

  dma_hdr_decode #(
    .WORD_BUDGET (WORD_BUDGET)
  ) u_hdr (
    .hdr        (in_data[HDR_RSV_HI:HDR_LSB]),
    .n_first    (dec_nf),
    .n_last     (dec_nl),
    .first_comp (dec_fcomp),
    .last_comp  (dec_lcomp),
    .rsv_bad    (dec_rsv),
    .budget_bad (dec_budget)
  );

  dma_len_unpack u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept && is_len_word),
    .word  (in_data),
    .sel   (slot_q),
    .len   (grp_len)
  );

  dma_size_tally u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept && (state_q == ST_HDR)),
    .add_first (accept && is_ptr && (state_q == ST_FIRST)),
    .add_last  (accept && is_ptr && (state_q == ST_LAST)),
    .val       (ptr_len),
    .mismatch  (sum_bad)
  );

  // word classification and field extraction
  always_comb begin
    in_ready    = !vld_q || out_ready;
    accept      = in_valid && in_ready;
    in_area     = (state_q != ST_HDR);
    cur_comp    = (state_q == ST_FIRST) ? fcomp_q : lcomp_q;
    is_len_word = in_area && cur_comp && (slot_q == '0);
    is_ptr      = in_area && !is_len_word;
    loc_size    = in_data[LOC_SIZE_LO +: SIZE_W];
    loc_rsv     = in_data[LOC_RSV_LO +: LOC_RSV_W];
    ptr_len     = cur_comp ? grp_len : LEN_W'(loc_size);
    ptr_addr    = cur_comp ? in_data : WORD_W'(in_data[LADDR_W-1:0]);
    area_end    = is_ptr && (left_q == CNT_W'(1));
    cmd_end     = area_end && ((state_q == ST_LAST) || (nlast_q == '0));
    hdr_only    = !in_area && (dec_nf == '0) && (dec_nl == '0);

    cur_flags = '0;
    if (!in_area) begin
      cur_flags[ERR_RSV]    = dec_rsv;
      cur_flags[ERR_BUDGET] = dec_budget;
    end else if (is_ptr && !cur_comp) begin
      cur_flags[ERR_RSV]  = |loc_rsv;
      cur_flags[ERR_ZERO] = (loc_size == '0);
    end
  end

  // completion report on the accepting cycle
  always_comb begin
    cmd_done = accept && (hdr_only || cmd_end);
    cmd_err  = '0;
    if (cmd_done) begin
      cmd_err          = (in_area ? err_q : '0) | cur_flags;
      cmd_err[ERR_SUM] = in_area && sum_bad;
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    slot_d  = slot_q;
    fcomp_d = fcomp_q;
    lcomp_d = lcomp_q;
    nlast_d = nlast_q;
    err_d   = err_q;
    desc_d  = desc_q;
    vld_d   = vld_q && !out_ready;

    if (accept) begin
      if (!in_area) begin
        err_d   = cur_flags;
        fcomp_d = dec_fcomp;
        lcomp_d = dec_lcomp;
        nlast_d = dec_nl;
        slot_d  = '0;
        if (dec_nf != '0) begin
          state_d = ST_FIRST;
          left_d  = dec_nf;
        end else if (dec_nl != '0) begin
          state_d = ST_LAST;
          left_d  = dec_nl;
        end
      end else begin
        err_d = err_q | cur_flags;
        if (is_len_word) begin
          slot_d = SLOT_W'(1);
        end else begin
          desc_d.area = (state_q == ST_LAST);
          desc_d.comp = cur_comp;
          desc_d.last = cmd_end;
          desc_d.len  = ptr_len;
          desc_d.addr = ptr_addr;
          vld_d       = 1'b1;
          left_d      = left_q - CNT_W'(1);
          if (!cur_comp || (slot_q == SLOT_W'(GROUP)) || area_end) begin
            slot_d = '0;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
          if (area_end) begin
            if ((state_q == ST_FIRST) && (nlast_q != '0)) begin
              state_d = ST_LAST;
              left_d  = nlast_q;
            end else begin
              state_d = ST_HDR;
            end
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      left_q  <= '0;
      slot_q  <= '0;
      fcomp_q <= 1'b0;
      lcomp_q <= 1'b0;
      nlast_q <= '0;
      err_q   <= '0;
      desc_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (accept) begin
        state_q <= state_d;
        left_q  <= left_d;
        slot_q  <= slot_d;
        fcomp_q <= fcomp_d;
        lcomp_q <= lcomp_d;
        nlast_q <= nlast_d;
        err_q   <= err_d;
        desc_q  <= desc_d;
      end
    end
  end

  always_comb begin
    out_valid = vld_q;
    out_area  = desc_q.area;
    out_comp  = desc_q.comp;
    out_last  = desc_q.last;
    out_len   = desc_q.len;
    out_addr  = desc_q.addr;
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready) else $error("stall"); // R11

  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
                                   && $stable(out_last))) else $error("held"); // R11

  AST_DONE_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (state_q == ST_HDR)) else $error("done"); // R6

  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (state_q == ST_HDR)) else $error("last"); // R5

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(GROUP)) else $error("slot"); // R2

  AST_LOCAL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_area && !cur_comp) |-> (slot_q == '0)) else $error("lslot"); // R2

endmodule

// File: tb/test_dma_cmd_parser.sv
`timescale 1ns/1ps
module test_dma_cmd_parser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        rdy = 1'b1;
  logic        out_area, out_comp, out_last;
  logic [15:0] out_len;
  logic [63:0] out_addr;
  logic        cmd_done;
  logic [3:0]  cmd_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dma_cmd_parser i_dma_cmd_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(rdy),
    .out_area(out_area), .out_comp(out_comp), .out_last(out_last),
    .out_len(out_len), .out_addr(out_addr), .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

  // descriptor collector (only writer of these)
  logic [63:0] d_addr [0:127];
  logic [15:0] d_len  [0:127];
  logic        d_area [0:127];
  logic        d_comp [0:127];
  logic        d_last [0:127];
  int          ndesc = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && rdy && ndesc < 128) begin
      d_addr[ndesc] = out_addr;
      d_len[ndesc]  = out_len;
      d_area[ndesc] = out_area;
      d_comp[ndesc] = out_comp;
      d_last[ndesc] = out_last;
      ndesc = ndesc + 1;
    end
  end

  logic [63:0] cw [0:63];
  int          ncw;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_hdr(input logic [1:0] kind, input logic [3:0] nf,
                                         input logic [3:0] nl, input logic [3:0] rsv);
    return {rsv, kind, nf, nl, 50'd0};
  endfunction

  function automatic logic [63:0] mk_loc(input logic [12:0] size, input logic [35:0] addr,
                                         input logic [3:0] rsv);
    return {11'h5a5, size, rsv, addr};
  endfunction

  function automatic logic [63:0] mk_len(input logic [15:0] a, input logic [15:0] b,
                                         input logic [15:0] c, input logic [15:0] d);
    return {a, b, c, d};
  endfunction

  task automatic push(input logic [63:0] w);
    cw[ncw] = w;
    ncw++;
  endtask

  task automatic send(input logic [63:0] w, output logic d, output logic [3:0] e);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    d = cmd_done;
    e = cmd_err;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [3:0] exp_err, input string tag);
    logic d;
    logic [3:0] e;
    for (int i = 0; i < ncw; i++) begin
      send(cw[i], d, e);
      if (i < ncw - 1) begin
        if (d) check(1'b0, {tag, " R6 early done"}, i, ncw - 1);
      end else begin
        check(d == 1'b1, {tag, " R6 done on final word"}, d, 1);
        check(e == exp_err, {tag, " error code"}, e, exp_err);
      end
    end
    repeat (4) @(posedge clk);
    #1;
    ncw = 0;
  endtask

  task automatic chk_desc(input int i, input logic area, input logic comp, input logic [15:0] len,
                          input logic [63:0] addr, input logic last, input string tag);
    check(d_area[i] == area, {tag, " R5 area tag"}, d_area[i], area);
    check(d_comp[i] == comp, {tag, " R3 comp flag"}, d_comp[i], comp);
    check(d_len[i] == len, {tag, " R2/R4 length"}, d_len[i], len);
    check(d_addr[i] == addr, {tag, " R4 address"}, d_addr[i], addr);
    check(d_last[i] == last, {tag, " R5 last tag"}, d_last[i], last);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R12 in_ready after reset", in_ready, 1);
    check(cmd_done == 1'b0, "R12 cmd_done after reset", cmd_done, 0);
  endtask

  task automatic t_l2b;
    int b = ndesc;
    push(mk_hdr(2'd0, 4'd2, 4'd3, 4'd0));
    push(mk_loc(13'd100, 36'h1_2345_6789, 4'd0));
    push(mk_loc(13'd28, 36'hA_0000_0040, 4'd0));
    push(mk_len(16'd50, 16'd50, 16'd28, 16'hFFFF));
    push(64'hC000_0000_0000_1000);
    push(64'hC000_0000_0000_2000);
    push(64'hC000_0000_0000_3000);
    run_cmd(4'd0, "l2b");
    check(ndesc - b == 5, "l2b R2 descriptor count", ndesc - b, 5);
    chk_desc(b+0, 0, 0, 16'd100, 64'h1_2345_6789, 0, "l2b d0");
    chk_desc(b+1, 0, 0, 16'd28, 64'hA_0000_0040, 0, "l2b d1");
    chk_desc(b+2, 1, 1, 16'd50, 64'hC000_0000_0000_1000, 0, "l2b d2");
    chk_desc(b+3, 1, 1, 16'd50, 64'hC000_0000_0000_2000, 0, "l2b d3");
    chk_desc(b+4, 1, 1, 16'd28, 64'hC000_0000_0000_3000, 1, "l2b d4");
  endtask

  task automatic t_b2b;
    int b = ndesc;
    push(mk_hdr(2'd3, 4'd5, 4'd1, 4'd0));
    push(mk_len(16'd10, 16'd20, 16'd30, 16'd40));
    for (int i = 0; i < 4; i++) push(64'h8000_0000_0000_0000 + 64'(i));
    push(mk_len(16'd50, 16'd7, 16'd7, 16'd7));
    push(64'h8000_0000_0000_0004);
    push(mk_len(16'd150, 16'd0, 16'd0, 16'd0));
    push(64'h9000_0000_0000_0000);
    run_cmd(4'd0, "b2b");
    check(ndesc - b == 6, "b2b R2 descriptor count", ndesc - b, 6);
    chk_desc(b+0, 0, 1, 16'd10, 64'h8000_0000_0000_0000, 0, "b2b d0");
    chk_desc(b+3, 0, 1, 16'd40, 64'h8000_0000_0000_0003, 0, "b2b d3");
    chk_desc(b+4, 0, 1, 16'd50, 64'h8000_0000_0000_0004, 0, "b2b d4 R2 second group");
    chk_desc(b+5, 1, 1, 16'd150, 64'h9000_0000_0000_0000, 1, "b2b d5");
  endtask

  task automatic t_l2l;
    int b = ndesc;
    push(mk_hdr(2'd2, 4'd1, 4'd2, 4'd0));
    push(mk_loc(13'd300, 36'h0_0000_1000, 4'd0));
    push(mk_loc(13'd200, 36'h0_0000_2000, 4'd0));
    push(mk_loc(13'd100, 36'h0_0000_3000, 4'd0));
    run_cmd(4'd0, "l2l");
    check(ndesc - b == 3, "l2l R3 descriptor count", ndesc - b, 3);
    chk_desc(b+1, 1, 0, 16'd200, 64'h1000 + 64'h1000, 0, "l2l d1 R3 local last area");
    chk_desc(b+2, 1, 0, 16'd100, 64'h3000, 1, "l2l d2");
  endtask

  task automatic t_hdr_only;
    int b = ndesc;
    push(mk_hdr(2'd1, 4'd0, 4'd0, 4'd0));
    run_cmd(4'd0, "R1 header-only");
    check(ndesc == b, "R1 header-only no descriptor", ndesc - b, 0);
    push(mk_hdr(2'd0, 4'd0, 4'd0, 4'hA));
    run_cmd(4'b0001, "R7 header reserved");
  endtask

  task automatic t_errors;
    push(mk_hdr(2'd2, 4'd1, 4'd1, 4'd0));
    push(mk_loc(13'd5, 36'h40, 4'd3));
    push(mk_loc(13'd5, 36'h80, 4'd0));
    run_cmd(4'b0001, "R7 local reserved");
    push(mk_hdr(2'd2, 4'd1, 4'd1, 4'd0));
    push(mk_loc(13'd0, 36'h40, 4'd0));
    push(mk_loc(13'd0, 36'h80, 4'd0));
    run_cmd(4'b0100, "R9 zero size");
    push(mk_hdr(2'd1, 4'd1, 4'd1, 4'd0));
    push(mk_loc(13'd10, 36'h40, 4'd0));
    push(mk_len(16'd11, 16'd0, 16'd0, 16'd0));
    push(64'hF0);
    run_cmd(4'b1000, "R10 sum mismatch");
  endtask

  task automatic t_budget;
    int b = ndesc;
    push(mk_hdr(2'd0, 4'd15, 4'd15, 4'd0));
    for (int i = 0; i < 15; i++) push(mk_loc(13'd1, 36'(i * 8), 4'd0));
    for (int g = 0; g < 4; g++) begin
      push(mk_len(16'd1, 16'd1, 16'd1, 16'd1));
      for (int k = 0; k < 4; k++) if (g * 4 + k < 15) push(64'h7000 + 64'(g * 4 + k));
    end
    check(ncw == 35, "R8 stimulus word count", ncw, 35);
    run_cmd(4'b0010, "R8 word budget");
    check(ndesc - b == 30, "R8 descriptor count", ndesc - b, 30);
    chk_desc(b+29, 1, 1, 16'd1, 64'h7000 + 64'd14, 1, "R8 final");
  endtask

  task automatic t_b2l_after_err;
    int b = ndesc;
    push(mk_hdr(2'd1, 4'd1, 4'd2, 4'd0));
    push(mk_loc(13'd64, 36'h0_0000_0100, 4'd0));
    push(mk_len(16'd32, 16'd32, 16'd0, 16'd0));
    push(64'h1111);
    push(64'h2222);
    run_cmd(4'd0, "b2l R6 header after error");
    chk_desc(b+0, 0, 0, 16'd64, 64'h100, 0, "b2l d0");
    chk_desc(b+2, 1, 1, 16'd32, 64'h2222, 1, "b2l d2");
  endtask

  task automatic t_stall;
    logic d;
    logic [3:0] e;
    logic [63:0] w2;
    int b = ndesc;
    rdy = 1'b0;
    send(mk_hdr(2'd2, 4'd1, 4'd1, 4'd0), d, e);
    send(mk_loc(13'd7, 36'h55, 4'd0), d, e);
    w2 = mk_loc(13'd7, 36'h66, 4'd0);
    in_valid = 1'b1;
    in_data  = w2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R11 descriptor pending", out_valid, 1);
      check(in_ready == 1'b0, "R11 in_ready low in stall", in_ready, 0);
      check(out_addr == 64'h55, "R11 descriptor held", out_addr, 64'h55);
      check(cmd_done == 1'b0, "R11 no done while stalled", cmd_done, 0);
    end
    @(posedge clk);
    #1;
    rdy = 1'b1;
    in_valid = 1'b0;
    send(w2, d, e);
    check(d == 1'b1, "R11 done after release", d, 1);
    check(e == 4'd0, "R11 error code", e, 0);
    repeat (4) @(posedge clk);
    #1;
    check(ndesc - b == 2, "R11 each descriptor once", ndesc - b, 2);
    chk_desc(b+0, 0, 0, 16'd7, 64'h55, 0, "stall d0");
    chk_desc(b+1, 1, 0, 16'd7, 64'h66, 1, "stall d1");
  endtask

  initial begin
    ncw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_l2b();
    t_b2b();
    t_l2l();
    t_hdr_only();
    t_errors();
    t_budget();
    t_b2l_after_err();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R6 actual=hung expected=complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule